// File: doc/BRIEF.md
# Trigger Line Routing Controller

This block connects a group of backplane trigger lines to a pair of front-panel trigger ports, one input and one output. A 16-bit control word decides, line by line, whether the line takes part in routing and, if it does, which way the signal flows. An outward line copies the backplane level to the front-panel output. An inward line lets the front-panel input drive that backplane line.

A host bus writes and reads the control word, either as a full word or through two byte-lane strobes. The routing is purely combinational from the stored word, so a write changes the routing from the clock edge that stores it. Two reset inputs are provided. The hard reset clears the word, which releases every backplane driver and silences the output. The soft reset keeps the word, so the routing stays as it was while the rest of the device recovers.

Triggers that the device raises itself are present only on the backplane. They reach the front-panel output only through a line that is enabled in the outward direction.

Top module: `trig_route_ctrl`

## Requirements
- R1: The stored word holds one enable bit per line at bit 8+i and one direction bit per line at bit i (line i, 0..7). `host_rdata` always shows the stored word, and reading it has no side effect.
- R2: While `hard_rst_n` is low, the stored word is 16'h0000. The clear is asynchronous and does not wait for a clock edge.
- R3: A low `soft_rst_n` leaves the stored word unchanged. Host writes presented while it is low are ignored.
- R4: On a write, `host_be[1]` stores `host_wdata[15:8]` into the enable field and `host_be[0]` stores `host_wdata[7:0]` into the direction field. Each lane is independent, and a write with both strobes low changes nothing.
- R5: A write presented before a rising edge is not visible on `host_rdata` or on the routing before that edge. It is visible on both right after the edge.
- R6: A line whose enable bit is 0 has `bp_drive_en` and `bp_drive_val` at 0, and it does not affect `fp_out`, whatever its direction bit holds.
- R7: `fp_out` is the OR of `bp_trig_in` over the lines that are enabled with direction bit 0. It is 0 when there is no such line.
- R8: A line that is enabled with direction bit 1 has `bp_drive_en` at 1 and `bp_drive_val` equal to `fp_in`.
- R9: An inward-enabled line never contributes to `fp_out`, even when its backplane input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| hard_rst_n | input | 1 | Active-low asynchronous reset; clears the control word |
| soft_rst_n | input | 1 | Active-low soft reset; keeps the control word and blocks writes |
| host_wr | input | 1 | Write request, sampled at the rising edge |
| host_be | input | 2 | Byte-lane strobes: [1] enable field, [0] direction field |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Current control word |
| bp_trig_in | input | 8 | Sensed level of each backplane trigger line |
| fp_in | input | 1 | Front-panel trigger input |
| bp_drive_en | output | 8 | Per-line backplane driver enable |
| bp_drive_val | output | 8 | Per-line backplane drive value |
| fp_out | output | 1 | Front-panel trigger output |

## Verification
Several properties are checked on every cycle:
- No backplane driver is enabled on a disabled or outward line.
- Drive values stay low on released lines.
- The output is silent when no outward-enabled line is high.
- The word is zero during hard reset.
- The word stays unchanged under soft reset and under strobe-free writes.
- A single-lane write leaves the other lane alone.

The directed scenarios are needed to show the rest:
- The exact values stored by full and partial writes.
- The cycle at which a write becomes visible.
- The OR that merges several outward lines.
- The input-port value carried onto inward lines.
- The hard reset clearing the word in mid-cycle.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;

    // Number of backplane trigger lines handled by the block.
    localparam int unsigned LINES = 8;

    // Width of the host-visible control word: one enable and one direction bit per line.
    localparam int unsigned WORD_W = 2 * LINES;

    // Number of byte-lane strobes; the upper lane holds enables, the lower lane directions.
    localparam int unsigned LANES = 2;

    typedef logic [LINES-1:0] line_vec_t;

    // Stored routing configuration; the packed order matches the host word layout.
    typedef struct packed {
        line_vec_t en;   // upper half of the host word
        line_vec_t dir;  // lower half of the host word, 1 = inward
    } route_cfg_t;

endpackage

// File: rtl/trig_route_regs.sv
module trig_route_regs
    import trig_route_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic             clk,
    input  logic             hard_rst_n,
    input  logic             soft_rst_n,
    input  logic             wr,
    input  logic [LANES-1:0] be,
    input  logic [W-1:0]     wdata,
    output route_cfg_t       cfg
);

    localparam int unsigned HALF = W / 2;

    typedef struct packed {
        route_cfg_t cfg;
    } regs_t;

    regs_t state_d;
    regs_t state_q;

    logic write_ok;

    always_comb begin
        state_d  = state_q;
        write_ok = wr && soft_rst_n;
        if (write_ok && be[1]) begin
            state_d.cfg.en = wdata[W-1:HALF];
        end
        if (write_ok && be[0]) begin
            state_d.cfg.dir = wdata[HALF-1:0];
        end
    end

    always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg = state_q.cfg;

endmodule

// File: rtl/trig_route_lane.sv
module trig_route_lane (
    input  logic en,
    input  logic dir,
    input  logic bp_in,
    input  logic fp_in,
    output logic drive_en,
    output logic drive_val,
    output logic out_term
);

    logic inward;
    logic outward;

    always_comb begin
        inward    = en && dir;
        outward   = en && !dir;
        drive_en  = inward;
        drive_val = inward && fp_in;
        out_term  = outward && bp_in;
    end

endmodule

// File: rtl/trig_route_ctrl.sv
module trig_route_ctrl
    import trig_route_pkg::*;
(
    input  logic        clk,
    input  logic        hard_rst_n,
    input  logic        soft_rst_n,
    input  logic        host_wr,
    input  logic [1:0]  host_be,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic [7:0]  bp_trig_in,
    input  logic        fp_in,
    output logic [7:0]  bp_drive_en,
    output logic [7:0]  bp_drive_val,
    output logic        fp_out
);

    route_cfg_t cfg;
    line_vec_t  out_terms;

    trig_route_regs #(
        .W (WORD_W)
    ) regs_i (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .soft_rst_n (soft_rst_n),
        .wr         (host_wr),
        .be         (host_be),
        .wdata      (host_wdata),
        .cfg        (cfg)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        trig_route_lane lane_i (
            .en        (cfg.en[i]),
            .dir       (cfg.dir[i]),
            .bp_in     (bp_trig_in[i]),
            .fp_in     (fp_in),
            .drive_en  (bp_drive_en[i]),
            .drive_val (bp_drive_val[i]),
            .out_term  (out_terms[i])
        );
    end

    assign host_rdata = cfg;
    assign fp_out     = |out_terms;

endmodule

// File: rtl/trig_route_chk.sv
module trig_route_chk (
    input logic        clk,
    input logic        hard_rst_n,
    input logic        soft_rst_n,
    input logic        host_wr,
    input logic [1:0]  host_be,
    input logic [15:0] host_wdata,
    input logic [15:0] host_rdata,
    input logic [7:0]  bp_trig_in,
    input logic [7:0]  bp_drive_en,
    input logic [7:0]  bp_drive_val,
    input logic        fp_out
);

    // R2
    hard_clear_chk: assert property (@(posedge clk)
        !hard_rst_n |-> host_rdata == 16'h0000);

    // R6
    no_drive_disabled_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (bp_drive_en & ~host_rdata[15:8]) == 8'h00);

    // R8
    no_drive_outward_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (bp_drive_en & ~host_rdata[7:0]) == 8'h00);

    // R6
    released_low_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (bp_drive_val & ~bp_drive_en) == 8'h00);

    // R7
    quiet_output_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        ((host_rdata[15:8] & ~host_rdata[7:0] & bp_trig_in) == 8'h00) |-> !fp_out);

    // R3
    soft_hold_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !soft_rst_n |=> $stable(host_rdata));

    // R4
    no_lane_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (host_wr && host_be == 2'b00) |=> $stable(host_rdata));

    // R4
    high_lane_only_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (host_wr && soft_rst_n && host_be == 2'b10) |=>
        (host_rdata[7:0] == $past(host_rdata[7:0]) &&
         host_rdata[15:8] == $past(host_wdata[15:8])));

    // R4
    low_lane_only_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (host_wr && soft_rst_n && host_be == 2'b01) |=>
        (host_rdata[15:8] == $past(host_rdata[15:8]) &&
         host_rdata[7:0] == $past(host_wdata[7:0])));

endmodule

bind trig_route_ctrl trig_route_chk chk_i (
    .clk          (clk),
    .hard_rst_n   (hard_rst_n),
    .soft_rst_n   (soft_rst_n),
    .host_wr      (host_wr),
    .host_be      (host_be),
    .host_wdata   (host_wdata),
    .host_rdata   (host_rdata),
    .bp_trig_in   (bp_trig_in),
    .bp_drive_en  (bp_drive_en),
    .bp_drive_val (bp_drive_val),
    .fp_out       (fp_out)
);

// File: tb/trig_route_ctrl_tb_top.sv
module trig_route_ctrl_tb_top;

    logic        clk;
    logic        hard_rst_n;
    logic        soft_rst_n;
    logic        host_wr;
    logic [1:0]  host_be;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic [7:0]  bp_trig_in;
    logic        fp_in;
    logic [7:0]  bp_drive_en;
    logic [7:0]  bp_drive_val;
    logic        fp_out;

    int checks;
    int errors;
    bit done;

    trig_route_ctrl dut_i (
        .clk          (clk),
        .hard_rst_n   (hard_rst_n),
        .soft_rst_n   (soft_rst_n),
        .host_wr      (host_wr),
        .host_be      (host_be),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .bp_trig_in   (bp_trig_in),
        .fp_in        (fp_in),
        .bp_drive_en  (bp_drive_en),
        .bp_drive_val (bp_drive_val),
        .fp_out       (fp_out)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] be, input logic [15:0] data);
        @(negedge clk);
        host_wr    = 1'b1;
        host_be    = be;
        host_wdata = data;
        @(negedge clk);
        host_wr    = 1'b0;
        host_be    = 2'b00;
        host_wdata = 16'h0000;
    endtask

    task automatic t_reset_state();
        check("R2 reset word", host_rdata, 16'h0000);
        check("R6 reset drive_en", {8'h00, bp_drive_en}, 16'h0000);
        check("R7 reset fp_out", {15'h0, fp_out}, 16'h0000);
    endtask

    task automatic t_word_rw();
        host_write(2'b11, 16'hA55A);
        check("R1 full word", host_rdata, 16'hA55A);
        #3;
        check("R1 read repeat", host_rdata, 16'hA55A);
    endtask

    task automatic t_byte_lanes();
        host_write(2'b11, 16'hA55A);
        host_write(2'b10, 16'h3C00);
        check("R4 high lane", host_rdata, 16'h3C5A);
        host_write(2'b01, 16'h00F0);
        check("R4 low lane", host_rdata, 16'h3CF0);
        host_write(2'b00, 16'hFFFF);
        check("R4 no lane", host_rdata, 16'h3CF0);
    endtask

    task automatic t_timing();
        host_write(2'b11, 16'h0000);
        bp_trig_in = 8'h01;
        @(negedge clk);
        host_wr    = 1'b1;
        host_be    = 2'b11;
        host_wdata = 16'h0100;
        #2;
        check("R5 before edge word", host_rdata, 16'h0000);
        check("R5 before edge route", {15'h0, fp_out}, 16'h0000);
        @(posedge clk);
        #2;
        check("R5 after edge word", host_rdata, 16'h0100);
        check("R5 after edge route", {15'h0, fp_out}, 16'h0001);
        @(negedge clk);
        host_wr    = 1'b0;
        host_be    = 2'b00;
        bp_trig_in = 8'h00;
    endtask

    task automatic t_disabled();
        host_write(2'b11, 16'h00FF);
        fp_in      = 1'b1;
        bp_trig_in = 8'hFF;
        #2;
        check("R6 disabled drive_en", {8'h00, bp_drive_en}, 16'h0000);
        check("R6 disabled drive_val", {8'h00, bp_drive_val}, 16'h0000);
        check("R6 disabled fp_out", {15'h0, fp_out}, 16'h0000);
        fp_in      = 1'b0;
        bp_trig_in = 8'h00;
    endtask

    task automatic t_outward();
        host_write(2'b11, 16'hFF00);
        bp_trig_in = 8'h00;
        #2;
        check("R7 outward idle", {15'h0, fp_out}, 16'h0000);
        bp_trig_in = 8'h10;
        #2;
        check("R7 outward one", {15'h0, fp_out}, 16'h0001);
        bp_trig_in = 8'h81;
        #2;
        check("R7 outward two", {15'h0, fp_out}, 16'h0001);
        check("R8 outward no drive", {8'h00, bp_drive_en}, 16'h0000);
        host_write(2'b11, 16'h0600);
        bp_trig_in = 8'hF9;
        #2;
        check("R7 unselected lines", {15'h0, fp_out}, 16'h0000);
        bp_trig_in = 8'h04;
        #2;
        check("R7 selected line", {15'h0, fp_out}, 16'h0001);
        bp_trig_in = 8'h00;
    endtask

    task automatic t_inward();
        host_write(2'b11, 16'hFFF0);
        fp_in = 1'b1;
        #2;
        check("R8 inward drive_en", {8'h00, bp_drive_en}, 16'h00F0);
        check("R8 inward drive_val high", {8'h00, bp_drive_val}, 16'h00F0);
        fp_in = 1'b0;
        #2;
        check("R8 inward drive_val low", {8'h00, bp_drive_val}, 16'h0000);
        check("R8 inward drive_en held", {8'h00, bp_drive_en}, 16'h00F0);
        bp_trig_in = 8'hF0;
        #2;
        check("R9 inward no loop", {15'h0, fp_out}, 16'h0000);
        bp_trig_in = 8'hF2;
        #2;
        check("R9 outward alongside", {15'h0, fp_out}, 16'h0001);
        bp_trig_in = 8'h00;
    endtask

    task automatic t_soft_reset();
        host_write(2'b11, 16'h1234);
        @(negedge clk);
        soft_rst_n = 1'b0;
        host_write(2'b11, 16'hFFFF);
        check("R3 soft reset write blocked", host_rdata, 16'h1234);
        @(negedge clk);
        soft_rst_n = 1'b1;
        #2;
        check("R3 soft reset keeps word", host_rdata, 16'h1234);
        fp_in = 1'b1;
        #2;
        check("R3 routing kept", {8'h00, bp_drive_en}, 16'h0010);
        fp_in = 1'b0;
    endtask

    task automatic t_hard_reset();
        host_write(2'b11, 16'hF0F0);
        @(negedge clk);
        #3;
        hard_rst_n = 1'b0;
        #1;
        check("R2 async clear", host_rdata, 16'h0000);
        check("R2 drivers released", {8'h00, bp_drive_en}, 16'h0000);
        @(negedge clk);
        hard_rst_n = 1'b1;
        #2;
        check("R2 stays clear", host_rdata, 16'h0000);
    endtask

    initial begin
        checks     = 0;
        errors     = 0;
        done       = 1'b0;
        hard_rst_n = 1'b0;
        soft_rst_n = 1'b1;
        host_wr    = 1'b0;
        host_be    = 2'b00;
        host_wdata = 16'h0000;
        bp_trig_in = 8'h00;
        fp_in      = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        t_reset_state();
        hard_rst_n = 1'b1;
        t_word_rw();
        t_byte_lanes();
        t_timing();
        t_disabled();
        t_outward();
        t_inward();
        t_soft_reset();
        t_hard_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule